// File: doc/BRIEF.md
# Grouped Interrupt Status Unit

This unit gathers single-cycle event pulses from two transfer channels and from a byte of generic external sources into one 32-bit raw status word. Each channel owns an 8-bit group of that word. Within a group, five event kinds each latch their own bit: command done, receive overrun, transmit underrun, poll timeout and invalid control. A set bit stays set until software writes a 1 to it.

A 32-bit mask register selects which status bits may raise the interrupt. A separate read-only view returns the raw status ANDed with the mask, and the interrupt output is the OR of that view, delayed by one register. Software reaches all three registers through a simple register port. The port takes a byte address, a write strobe and write data, and its read data is combinational. An interrupt service routine typically reads the masked view, clears everything with one write of 0xff001f1f, and reprograms the mask.

Top module: `isu_grp_irq`

## Requirements
- R1: A pulse on event k (0 command done, 1 receive overrun, 2 transmit underrun, 3 poll timeout, 4 invalid control) of channel i, on input bit i*5+k of `ch_evt_i`, sets raw status bit i*8+k at the next clock edge.
- R2: A pulse on bit j of `ext_evt_i` sets raw status bit 24+j at the next clock edge.
- R3: Raw status bits 7:5 and 23:13 are not implemented: they always read zero and no event or write sets them, so the implemented set is 0xff001f1f.
- R4: Raw status reads at byte offset 0x08. A write there clears each bit whose write-data bit is 1 and leaves the others unchanged. Writing 0xff001f1f clears every bit.
- R5: When an event and a write-1-clear reach the same bit in the same cycle, the bit ends up set.
- R6: The mask reads and writes at offset 0x10, holds all 32 bits, and is zero after reset.
- R7: Offset 0x0C reads raw status AND mask. Writes to that offset change neither the status nor the mask.
- R8: `irq_o` equals the OR of the masked view as it stood one cycle earlier, so it is low after reset and stays low while the mask is zero.
- R9: Reads at any other offset return zero, and writes there have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational on addr_i) |
| ch_evt_i | input | 10 | Channel event pulses, channel i event k on bit i*5+k |
| ext_evt_i | input | 8 | Generic external event pulses |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an event pulse and a write-1-clear landing on the same status bit in the same clock cycle. The bench drives both the event input and the register write on a single falling edge. It does this for the bit under clear and, separately, for a neighbouring bit, so that set priority and per-bit isolation are checked together. The one-cycle interrupt latency is exposed by sweeping single-bit masks from a zero mask. After each mask write, the bench samples the output once before and once after the register stage.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int unsigned STAT_W = 32;

  typedef enum logic [2:0] {
    EV_CMD_DONE  = 3'd0,
    EV_RX_OVR    = 3'd1,
    EV_TX_UND    = 3'd2,
    EV_POLL_TMO  = 3'd3,
    EV_CTRL_BAD  = 3'd4
  } chan_evt_e;

  // bits that hold state: channel groups plus the external field
  function automatic logic [STAT_W-1:0] impl_bits(int unsigned num_ch, int unsigned ch_evt,
                                                 int unsigned stride, int unsigned ext_lsb,
                                                 int unsigned ext_w);
    logic [STAT_W-1:0] m;
    m = '0;
    for (int unsigned c = 0; c < num_ch; c++)
      for (int unsigned k = 0; k < ch_evt; k++)
        m[c*stride+k] = 1'b1;
    for (int unsigned j = 0; j < ext_w; j++)
      m[ext_lsb+j] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/isu_evt_map.sv
module isu_evt_map #(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned CH_EVT  = 5,
  parameter int unsigned STRIDE  = 8,
  parameter int unsigned EXT_W   = 8,
  parameter int unsigned EXT_LSB = 24,
  localparam int unsigned STAT_W = isu_pkg::STAT_W
) (
  input  logic [NUM_CH*CH_EVT-1:0] ch_evt_i,
  input  logic [EXT_W-1:0]         ext_evt_i,
  output logic [STAT_W-1:0]        evt_o
);
  logic [NUM_CH-1:0][STAT_W-1:0] grp_v;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      grp_v[c] = '0;
      grp_v[c][c*STRIDE +: CH_EVT] = ch_evt_i[c*CH_EVT +: CH_EVT];
    end
  end

  always_comb begin
    evt_o = '0;
    evt_o[EXT_LSB +: EXT_W] = ext_evt_i;
    for (int unsigned c = 0; c < NUM_CH; c++) evt_o = evt_o | grp_v[c];
  end
endmodule

// File: rtl/isu_raw_stat.sv
module isu_raw_stat #(
  parameter logic [isu_pkg::STAT_W-1:0] IMPL = '1,
  localparam int unsigned STAT_W = isu_pkg::STAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] evt_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] raw_o
);
  logic [STAT_W-1:0] raw_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= (evt_i | (raw_q & ~clr_i)) & IMPL;
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/isu_mask_reg.sv
module isu_mask_reg #(
  localparam int unsigned STAT_W = isu_pkg::STAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/isu_irq_out.sv
module isu_irq_out #(
  localparam int unsigned STAT_W = isu_pkg::STAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] masked_i,
  output logic              irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |masked_i;
  end
endmodule

// File: rtl/isu_grp_irq.sv
module isu_grp_irq #(
  parameter int unsigned NUM_CH     = 2,
  parameter int unsigned CH_EVT     = 5,
  parameter int unsigned STRIDE     = 8,
  parameter int unsigned EXT_W      = 8,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned OFS_RAW    = 'h08,
  parameter int unsigned OFS_MASKED = 'h0C,
  parameter int unsigned OFS_MASK   = 'h10,
  localparam int unsigned STAT_W    = isu_pkg::STAT_W,
  localparam int unsigned EXT_LSB   = STAT_W - EXT_W,
  localparam int unsigned CH_W      = NUM_CH * CH_EVT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] rdata_o,
  input  logic [CH_W-1:0]   ch_evt_i,
  input  logic [EXT_W-1:0]  ext_evt_i,
  output logic              irq_o
);
  localparam logic [STAT_W-1:0] IMPL =
    isu_pkg::impl_bits(NUM_CH, CH_EVT, STRIDE, EXT_LSB, EXT_W);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);

  logic [STAT_W-1:0] evt_v, clr_v, raw_q, mask_q, masked_v;
  logic              sel_raw, sel_mask;

  assign sel_raw  = we_i && (addr_i == A_RAW);
  assign sel_mask = we_i && (addr_i == A_MASK);
  assign clr_v    = sel_raw ? wdata_i : '0;

  isu_evt_map #(
    .NUM_CH(NUM_CH), .CH_EVT(CH_EVT), .STRIDE(STRIDE),
    .EXT_W(EXT_W), .EXT_LSB(EXT_LSB)
  ) u_map (
    .ch_evt_i (ch_evt_i),
    .ext_evt_i(ext_evt_i),
    .evt_o    (evt_v)
  );

  isu_raw_stat #(.IMPL(IMPL)) u_raw (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_v),
    .clr_i (clr_v),
    .raw_o (raw_q)
  );

  isu_mask_reg u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (sel_mask),
    .wdata_i(wdata_i),
    .mask_o (mask_q)
  );

  assign masked_v = raw_q & mask_q;

  isu_irq_out u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .masked_i(masked_v),
    .irq_o   (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_RAW)         rdata_o = raw_q;
    else if (addr_i == A_MASKED) rdata_o = masked_v;
    else if (addr_i == A_MASK)   rdata_o = mask_q;
  end
endmodule

// File: rtl/isu_grp_irq_chk.sv
module isu_grp_irq_chk #(
  parameter int unsigned NUM_CH     = 2,
  parameter int unsigned CH_EVT     = 5,
  parameter int unsigned STRIDE     = 8,
  parameter int unsigned EXT_W      = 8,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned OFS_RAW    = 'h08,
  parameter int unsigned OFS_MASKED = 'h0C,
  parameter int unsigned OFS_MASK   = 'h10,
  localparam int unsigned STAT_W    = isu_pkg::STAT_W,
  localparam int unsigned EXT_LSB   = STAT_W - EXT_W,
  localparam int unsigned CH_W      = NUM_CH * CH_EVT
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [STAT_W-1:0] wdata_i,
  input logic [STAT_W-1:0] rdata_o,
  input logic [CH_W-1:0]   ch_evt_i,
  input logic [EXT_W-1:0]  ext_evt_i,
  input logic              irq_o,
  input logic [STAT_W-1:0] raw_q,
  input logic [STAT_W-1:0] mask_q
);
  localparam logic [STAT_W-1:0] IMPL =
    isu_pkg::impl_bits(NUM_CH, CH_EVT, STRIDE, EXT_LSB, EXT_W);

  logic [STAT_W-1:0] ev;
  logic              wr_raw, wr_mask;

  always_comb begin
    ev = '0;
    for (int unsigned i = 0; i < CH_W; i++)
      ev[(i / CH_EVT) * STRIDE + (i % CH_EVT)] = ch_evt_i[i];
    for (int unsigned j = 0; j < EXT_W; j++)
      ev[EXT_LSB + j] = ext_evt_i[j];
  end

  assign wr_raw  = we_i && (addr_i == ADDR_W'(OFS_RAW));
  assign wr_mask = we_i && (addr_i == ADDR_W'(OFS_MASK));

  // R1 R2: events latch
  a_r1_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev) |=> ((raw_q & $past(ev)) == $past(ev)));

  a_r3_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFS_RAW)) |-> ((rdata_o & ~IMPL) == '0));

  a_r4_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_raw |=> ((raw_q & $past(wdata_i & ~ev)) == '0));

  a_r4_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(ev)) == '0));

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_raw && |(ev & wdata_i)) |=> ((raw_q & $past(ev & wdata_i)) == $past(ev & wdata_i)));

  a_r6_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask |=> $stable(mask_q));

  a_r7_masked_view: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFS_MASKED)) |-> (rdata_o == (raw_q & mask_q)));

  a_r8_irq_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(raw_q & mask_q)) |=> irq_o);

  a_r8_irq_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(raw_q & mask_q)) |=> !irq_o);
endmodule

bind isu_grp_irq isu_grp_irq_chk #(
  .NUM_CH(NUM_CH), .CH_EVT(CH_EVT), .STRIDE(STRIDE), .EXT_W(EXT_W),
  .ADDR_W(ADDR_W), .OFS_RAW(OFS_RAW), .OFS_MASKED(OFS_MASKED), .OFS_MASK(OFS_MASK)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .ch_evt_i (ch_evt_i),
  .ext_evt_i(ext_evt_i),
  .irq_o    (irq_o),
  .raw_q    (raw_q),
  .mask_q   (mask_q)
);

// File: tb/tb_isu_grp_irq.sv
module tb_isu_grp_irq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [9:0]  ch_evt_i = '0;
  logic [7:0]  ext_evt_i = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] m_raw, m_mask, got;

  localparam logic [4:0] A_RAW = 5'h08, A_MSKD = 5'h0C, A_MASK = 5'h10, A_OTH = 5'h04;

  isu_grp_irq dut (.*);

  always #10 clk_i = ~clk_i;

  function automatic bit is_impl(int b);
    return (b < 16 && (b % 8) < 5) || b >= 24;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic set_evt(int b, logic v);
    if (b >= 24) ext_evt_i[b-24] = v;
    else if (is_impl(b)) ch_evt_i[(b / 8) * 5 + (b % 8)] = v;
  endtask

  task automatic pulse(int b);
    @(negedge clk_i);
    set_evt(b, 1'b1);
    @(negedge clk_i);
    set_evt(b, 1'b0);
    if (is_impl(b)) m_raw[b] = 1'b1;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
    if (a == A_RAW) m_raw = m_raw & ~d;
    if (a == A_MASK) m_mask = d;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  initial begin
    m_raw = '0; m_mask = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // reset state
    rd(A_RAW, got);  chk("R4 reset raw", got, 32'h0);
    rd(A_MASK, got); chk("R6 reset mask", got, 32'h0);
    rd(A_MSKD, got); chk("R7 reset masked", got, 32'h0);
    chk("R8 reset irq", {31'b0, irq_o}, 32'h0);

    // R1 R2 R3: per-bit event sweep
    for (int b = 0; b < 32; b++) begin
      pulse(b);
      rd(A_RAW, got);
      chk(b >= 24 ? "R2 ext event" : (is_impl(b) ? "R1 chan event" : "R3 unimpl bit"), got, m_raw);
      chk("R8 irq with zero mask", {31'b0, irq_o}, 32'h0);
    end
    chk("R3 implemented set", m_raw, 32'hff001f1f);

    // R4 write of zeros leaves status
    wr(A_RAW, 32'h0);
    rd(A_RAW, got); chk("R4 zero write", got, m_raw);

    // R6 R7 R8: single-bit mask sweep
    for (int b = 0; b < 32; b++) begin
      wr(A_MASK, 32'h1 << b);
      chk("R8 irq latency", {31'b0, irq_o}, 32'h0);
      @(negedge clk_i);
      chk("R8 irq value", {31'b0, irq_o}, {31'b0, |(m_raw & m_mask)});
      rd(A_MASK, got); chk("R6 mask readback", got, m_mask);
      rd(A_MSKD, got); chk("R7 masked view", got, m_raw & m_mask);
      wr(A_MASK, 32'h0);
      @(negedge clk_i);
      chk("R8 irq drops", {31'b0, irq_o}, 32'h0);
    end

    // R7 R9: ignored writes
    wr(A_MASK, 32'h0f0f0f0f);
    @(negedge clk_i); we_i = 1'b1; addr_i = A_MSKD; wdata_i = 32'hffffffff;
    @(negedge clk_i); we_i = 1'b0;
    rd(A_RAW, got);  chk("R7 write to masked raw", got, m_raw);
    rd(A_MASK, got); chk("R7 write to masked mask", got, m_mask);
    @(negedge clk_i); we_i = 1'b1; addr_i = A_OTH; wdata_i = 32'hffffffff;
    @(negedge clk_i); we_i = 1'b0;
    rd(A_OTH, got);  chk("R9 other read", got, 32'h0);
    rd(A_RAW, got);  chk("R9 other write raw", got, m_raw);
    rd(A_MASK, got); chk("R9 other write mask", got, m_mask);

    // R4: bit-by-bit clear with all bits enabled
    wr(A_MASK, 32'hffffffff);
    for (int b = 0; b < 32; b++) begin
      wr(A_RAW, 32'h1 << b);
      rd(A_RAW, got); chk("R4 w1c bit", got, m_raw);
      @(negedge clk_i);
      chk("R8 irq after clear", {31'b0, irq_o}, {31'b0, |m_raw});
    end

    // R5: set and clear collide on bit 0, neighbour bit 1 set
    pulse(0);
    @(negedge clk_i);
    set_evt(0, 1'b1); set_evt(1, 1'b1);
    we_i = 1'b1; addr_i = A_RAW; wdata_i = 32'h3;
    @(negedge clk_i);
    set_evt(0, 1'b0); set_evt(1, 1'b0); we_i = 1'b0;
    m_raw = 32'h3;
    rd(A_RAW, got); chk("R5 set wins", got, m_raw);
    @(negedge clk_i);
    set_evt(24, 1'b1); we_i = 1'b1; addr_i = A_RAW; wdata_i = 32'h1;
    @(negedge clk_i);
    set_evt(24, 1'b0); we_i = 1'b0;
    m_raw = 32'h0100_0002;
    rd(A_RAW, got); chk("R5 clear one set other", got, m_raw);

    // R3 R4: all events together, then clear-all
    @(negedge clk_i); ch_evt_i = '1; ext_evt_i = '1;
    @(negedge clk_i); ch_evt_i = '0; ext_evt_i = '0;
    rd(A_RAW, got); chk("R3 all events", got, 32'hff001f1f);
    wr(A_RAW, 32'hff001f1f);
    rd(A_RAW, got); chk("R4 clear all", got, 32'h0);
    @(negedge clk_i);
    chk("R8 irq after clear all", {31'b0, irq_o}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule